// File: doc/BRIEF.md
# Age-Ordered Instruction Issue Queue

This block holds instructions that an out-of-order core has dispatched but not yet sent to execution. Each instruction arrives with two source operand tags, a flag per source saying whether that operand already exists, a destination tag and a 5-bit sequence number that encodes program age. Instructions sit in one of eight slots until both operands are available. Operands become available when a matching tag appears on the result-broadcast bus.

Each cycle the queue offers one instruction whose operands are complete. When several qualify, the oldest one by sequence number is chosen, so selection does not depend on which slot an instruction landed in. A waiting older instruction does not block a younger one that is already complete. A slot is freed when its instruction is taken on the issue port, or when a misspeculation flush squashes it. A flush removes every instruction younger than the flush sequence number in one cycle.

Dispatch is a valid/ready interface. A dispatch is accepted only in a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is low while the queue is full or a flush is active. A dispatch attempted in such a cycle is dropped, and the producer must hold it and present it again. Issue is also a valid/ready interface. The offered instruction leaves the queue at the rising edge where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low, the offered instruction stays queued. The offer may switch to an older instruction if that instruction becomes ready in the meantime.

Top module: `ooo_issue_queue`

## Requirements
- R1: After reset the queue is empty: `iss_valid` = 0, `iq_full` = 0, `disp_ready` = 1.
- R2: An instruction is never offered while either of its source ready bits is clear.
- R3: A broadcast with `wk_valid` = 1 sets the ready bit of every stored source whose tag equals `wk_tag`. The instruction can be offered from the cycle after the broadcast, not in the broadcast cycle.
- R4: An instruction dispatched in the same cycle as a broadcast stores as ready any source whose tag equals `wk_tag`, even if its dispatch ready flag is 0.
- R5: Among instructions with complete operands, the one offered is the oldest. Sequence numbers are compared modulo 32: `a` is older than `b` when (b - a) mod 32 lies in 1..15. The slot position of an instruction does not affect this choice.
- R6: A complete younger instruction is offered while an older instruction is still waiting for operands.
- R7: The offered instruction leaves at the rising edge where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low it remains queued and `iss_valid` stays high.
- R8: When `flush_valid` = 1, every queued instruction whose sequence number is younger than `flush_seq` is removed at the next edge. An instruction with a sequence number equal to or older than `flush_seq` is kept.
- R9: During a flush cycle `iss_valid` = 0 and `disp_ready` = 0. No instruction issues and none is accepted in that cycle.
- R10: When all 8 slots are occupied, `iq_full` = 1 and `disp_ready` = 0. A dispatch presented then is ignored and never appears at the issue port.
- R11: A slot freed by issue can accept a new dispatch in the next cycle. `iq_full` drops in the cycle after the issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Queue can accept a dispatch this cycle |
| disp_src0_tag | input | 6 | Tag of first source operand |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | 6 | Tag of second source operand |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst_tag | input | 6 | Destination tag of the instruction |
| disp_seq | input | 5 | Age sequence number of the instruction |
| iq_full | output | 1 | All slots occupied |
| wk_valid | input | 1 | Result broadcast present |
| wk_tag | input | 6 | Tag of the broadcast result |
| iss_valid | output | 1 | An instruction is offered for issue |
| iss_ready | input | 1 | Consumer takes the offered instruction |
| iss_dst_tag | output | 6 | Destination tag of the offered instruction |
| iss_seq | output | 5 | Sequence number of the offered instruction |
| flush_valid | input | 1 | Misspeculation flush |
| flush_seq | input | 5 | Age boundary of the flush |

## Verification
The assertions assume that sequence numbers are dispatched in increasing modular order. They also assume that the live instructions, together with any flush boundary, always span fewer than 16 consecutive sequence values, so that the modular age comparison stays unambiguous. The directed stimulus keeps every live set within a short window of consecutive numbers, including one window that wraps from 30 through 31 to 1. It lets the queue drain completely between scenarios, so no stale sequence number stays alive across a wrap.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_SLOTS_DEF = 8;
  localparam int unsigned IQ_TAG_W_DEF = 6;
  localparam int unsigned IQ_SEQ_W_DEF = 5;
endpackage

// File: rtl/iq_slot.sv
module iq_slot #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned SEQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_src0_tag,
  input  logic             wr_src0_rdy,
  input  logic [TAG_W-1:0] wr_src1_tag,
  input  logic             wr_src1_rdy,
  input  logic [TAG_W-1:0] wr_dst_tag,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             issue_take,
  input  logic             flush_valid,
  input  logic [SEQ_W-1:0] flush_seq,
  output logic             valid,
  output logic             operands_ready,
  output logic [TAG_W-1:0] dst_tag,
  output logic [SEQ_W-1:0] seq
);

  // a is younger than b when (a - b) mod 2^SEQ_W is non-zero and in the lower half
  function automatic logic younger_than(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return (diff != '0) && !diff[SEQ_W-1];
  endfunction

  logic             valid_q;
  logic [TAG_W-1:0] tag0_q, tag1_q, dst_q;
  logic             rdy0_q, rdy1_q;
  logic [SEQ_W-1:0] seq_q;

  logic squash, wk_hit0, wk_hit1, wr_hit0, wr_hit1;

  assign squash  = flush_valid && valid_q && younger_than(seq_q, flush_seq);
  assign wk_hit0 = wk_valid && (wk_tag == tag0_q);
  assign wk_hit1 = wk_valid && (wk_tag == tag1_q);
  assign wr_hit0 = wk_valid && (wk_tag == wr_src0_tag);
  assign wr_hit1 = wk_valid && (wk_tag == wr_src1_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag0_q  <= '0;
      tag1_q  <= '0;
      rdy0_q  <= 1'b0;
      rdy1_q  <= 1'b0;
      dst_q   <= '0;
      seq_q   <= '0;
    end else if (squash || issue_take) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      tag0_q  <= wr_src0_tag;
      tag1_q  <= wr_src1_tag;
      rdy0_q  <= wr_src0_rdy || wr_hit0;
      rdy1_q  <= wr_src1_rdy || wr_hit1;
      dst_q   <= wr_dst_tag;
      seq_q   <= wr_seq;
    end else begin
      if (wk_hit0) rdy0_q <= 1'b1;
      if (wk_hit1) rdy1_q <= 1'b1;
    end
  end

  assign valid          = valid_q;
  assign operands_ready = valid_q && rdy0_q && rdy1_q;
  assign dst_tag        = dst_q;
  assign seq            = seq_q;

  AST_WRITE_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !valid_q); // R10
  AST_TAKE_NEEDS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_take |-> (valid_q && rdy0_q && rdy1_q)); // R2
  AST_WAKE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && wk_hit0 && !squash && !issue_take) |=> rdy0_q); // R3
  AST_CAPTURE_ON_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit1 && !issue_take) |=> rdy1_q); // R4
  AST_SQUASH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !valid_q); // R8
  AST_FLUSH_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !issue_take); // R9

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int unsigned SLOTS = 8
) (
  input  logic [SLOTS-1:0] occupied,
  output logic [SLOTS-1:0] free_sel,
  output logic             full
);

  always_comb begin
    logic found;
    found    = 1'b0;
    free_sel = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!occupied[i] && !found) begin
        free_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign full = &occupied;

endmodule

// File: rtl/iq_age_pick.sv
module iq_age_pick #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned SEQ_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            req,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
  output logic [SLOTS-1:0]            grant,
  output logic                        any
);

  // a is older than b when (b - a) mod 2^SEQ_W is non-zero and in the lower half
  function automatic logic older_than(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = b - a;
    return (diff != '0) && !diff[SEQ_W-1];
  endfunction

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      grant[i] = req[i];
      for (int j = 0; j < SLOTS; j++) begin
        if (j != i && req[j]) begin
          if (older_than(seq[j], seq[i]) || (j < i && seq[j] == seq[i]))
            grant[i] = 1'b0;
        end
      end
    end
  end

  assign any = |grant;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ((grant & req) != '0)); // R5

endmodule

// File: rtl/ooo_issue_queue.sv
module ooo_issue_queue
  import iq_pkg::*;
#(
  parameter int unsigned SLOTS = IQ_SLOTS_DEF,
  parameter int unsigned TAG_W = IQ_TAG_W_DEF,
  parameter int unsigned SEQ_W = IQ_SEQ_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [TAG_W-1:0] disp_src0_tag,
  input  logic             disp_src0_rdy,
  input  logic [TAG_W-1:0] disp_src1_tag,
  input  logic             disp_src1_rdy,
  input  logic [TAG_W-1:0] disp_dst_tag,
  input  logic [SEQ_W-1:0] disp_seq,
  output logic             iq_full,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [TAG_W-1:0] iss_dst_tag,
  output logic [SEQ_W-1:0] iss_seq,
  input  logic             flush_valid,
  input  logic [SEQ_W-1:0] flush_seq
);

  logic [SLOTS-1:0]            slot_valid, slot_ops, slot_wr, slot_take;
  logic [SLOTS-1:0]            free_sel, grant;
  logic [SLOTS-1:0][TAG_W-1:0] slot_dst;
  logic [SLOTS-1:0][SEQ_W-1:0] slot_seq;
  logic                        full, any_grant, disp_fire, iss_fire;

  iq_alloc #(.SLOTS(SLOTS)) u_alloc (
    .occupied (slot_valid),
    .free_sel (free_sel),
    .full     (full)
  );

  assign disp_ready = !full && !flush_valid;
  assign disp_fire  = disp_valid && disp_ready;
  assign iq_full    = full;

  iq_age_pick #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (slot_ops),
    .seq   (slot_seq),
    .grant (grant),
    .any   (any_grant)
  );

  assign iss_valid = any_grant && !flush_valid;
  assign iss_fire  = iss_valid && iss_ready;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign slot_wr[i]   = disp_fire && free_sel[i];
    assign slot_take[i] = iss_fire && grant[i];

    iq_slot #(.TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_slot (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (slot_wr[i]),
      .wr_src0_tag    (disp_src0_tag),
      .wr_src0_rdy    (disp_src0_rdy),
      .wr_src1_tag    (disp_src1_tag),
      .wr_src1_rdy    (disp_src1_rdy),
      .wr_dst_tag     (disp_dst_tag),
      .wr_seq         (disp_seq),
      .wk_valid       (wk_valid),
      .wk_tag         (wk_tag),
      .issue_take     (slot_take[i]),
      .flush_valid    (flush_valid),
      .flush_seq      (flush_seq),
      .valid          (slot_valid[i]),
      .operands_ready (slot_ops[i]),
      .dst_tag        (slot_dst[i]),
      .seq            (slot_seq[i])
    );
  end

  always_comb begin
    iss_dst_tag = '0;
    iss_seq     = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (grant[i]) begin
        iss_dst_tag = iss_dst_tag | slot_dst[i];
        iss_seq     = iss_seq | slot_seq[i];
      end
    end
  end

  AST_FULL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_full && !flush_valid && !iss_fire) |=> iq_full); // R10
  AST_OFFER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid || flush_valid)); // R7
  AST_FLUSH_BLOCKS_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !slot_valid[0]) |=> !slot_valid[0]); // R9

endmodule

// File: tb/ooo_issue_queue_bench.sv
`timescale 1ns/1ps
module ooo_issue_queue_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0;
  logic       disp_ready;
  logic [5:0] disp_src0_tag = '0;
  logic       disp_src0_rdy = 1'b0;
  logic [5:0] disp_src1_tag = '0;
  logic       disp_src1_rdy = 1'b0;
  logic [5:0] disp_dst_tag = '0;
  logic [4:0] disp_seq = '0;
  logic       iq_full;
  logic       wk_valid = 1'b0;
  logic [5:0] wk_tag = '0;
  logic       iss_valid;
  logic       iss_ready = 1'b0;
  logic [5:0] iss_dst_tag;
  logic [4:0] iss_seq;
  logic       flush_valid = 1'b0;
  logic [4:0] flush_seq = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ooo_issue_queue u_ooo_issue_queue (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
    .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
    .disp_dst_tag(disp_dst_tag), .disp_seq(disp_seq),
    .iq_full(iq_full), .wk_valid(wk_valid), .wk_tag(wk_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dst_tag(iss_dst_tag), .iss_seq(iss_seq),
    .flush_valid(flush_valid), .flush_seq(flush_seq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic dispatch(input int t0, input bit r0, input int t1, input bit r1,
                          input int dst, input int sq);
    disp_src0_tag = 6'(t0); disp_src0_rdy = r0;
    disp_src1_tag = 6'(t1); disp_src1_rdy = r1;
    disp_dst_tag  = 6'(dst); disp_seq = 5'(sq);
    disp_valid = 1'b1;
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic broadcast(input int tag);
    wk_valid = 1'b1; wk_tag = 6'(tag);
    tick();
    wk_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input int dst);
    iss_ready = 1'b1;
    #1;
    check(req, "iss_valid on pop", int'(iss_valid), 1);
    check(req, "iss_dst_tag on pop", int'(iss_dst_tag), dst);
    tick();
    iss_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "iss_valid after reset", int'(iss_valid), 0);
    check("R1", "iq_full after reset", int'(iq_full), 0);
    check("R1", "disp_ready after reset", int'(disp_ready), 1);
  endtask

  task automatic t_wakeup();
    dispatch(5, 0, 6, 1, 1, 0);
    check("R2", "waiting entry offered", int'(iss_valid), 0);
    wk_valid = 1'b1; wk_tag = 6'd5;
    #1;
    check("R3", "offered in broadcast cycle", int'(iss_valid), 0);
    tick();
    wk_valid = 1'b0;
    check("R3", "iss_valid after broadcast", int'(iss_valid), 1);
    check("R3", "dst after broadcast", int'(iss_dst_tag), 1);
    pop_expect("R3", 1);
    check("R7", "empty after pop", int'(iss_valid), 0);
  endtask

  task automatic t_capture();
    wk_valid = 1'b1; wk_tag = 6'd9;
    dispatch(9, 0, 10, 1, 2, 1);
    wk_valid = 1'b0;
    check("R4", "captured readiness", int'(iss_valid), 1);
    check("R4", "captured dst", int'(iss_dst_tag), 2);
    pop_expect("R4", 2);
  endtask

  task automatic t_age();
    dispatch(0, 1, 0, 1, 3, 28);
    dispatch(21, 0, 0, 1, 4, 29);
    pop_expect("R5", 3);
    dispatch(0, 1, 0, 1, 5, 30);
    check("R6", "younger ready offered", int'(iss_dst_tag), 5);
    check("R6", "younger ready valid", int'(iss_valid), 1);
    broadcast(21);
    check("R5", "older beats lower slot", int'(iss_dst_tag), 4);
    pop_expect("R5", 4);
    pop_expect("R5", 5);
    dispatch(0, 1, 0, 1, 6, 30);
    dispatch(22, 0, 0, 1, 7, 31);
    pop_expect("R5", 6);
    dispatch(22, 0, 0, 1, 8, 1);
    check("R2", "both waiting", int'(iss_valid), 0);
    broadcast(22);
    check("R5", "wrap: 31 older than 1", int'(iss_dst_tag), 7);
    pop_expect("R5", 7);
    pop_expect("R5", 8);
    check("R5", "empty after wrap test", int'(iss_valid), 0);
  endtask

  task automatic t_hold();
    dispatch(0, 1, 0, 1, 9, 2);
    for (int k = 0; k < 2; k++) begin
      check("R7", "held valid", int'(iss_valid), 1);
      check("R7", "held dst", int'(iss_dst_tag), 9);
      tick();
    end
    pop_expect("R7", 9);
    check("R7", "removed after take", int'(iss_valid), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) dispatch(0, 1, 0, 1, 16 + i, 3 + i);
    check("R10", "iq_full when 8 held", int'(iq_full), 1);
    check("R10", "disp_ready when full", int'(disp_ready), 0);
    dispatch(0, 1, 0, 1, 50, 11);
    pop_expect("R11", 16);
    check("R11", "iq_full after pop", int'(iq_full), 0);
    check("R11", "disp_ready after pop", int'(disp_ready), 1);
    dispatch(0, 1, 0, 1, 51, 12);
    check("R11", "refilled slot", int'(iq_full), 1);
    for (int i = 1; i < 8; i++) pop_expect("R5", 16 + i);
    pop_expect("R11", 51);
    check("R10", "ignored dispatch absent", int'(iss_valid), 0);
  endtask

  task automatic t_flush();
    dispatch(30, 0, 0, 1, 30, 13);
    dispatch(30, 0, 0, 1, 31, 14);
    dispatch(0, 1, 0, 1, 32, 15);
    dispatch(31, 0, 0, 1, 33, 16);
    check("R6", "ready younger offered", int'(iss_dst_tag), 32);
    flush_valid = 1'b1; flush_seq = 5'd14;
    iss_ready = 1'b1;
    disp_src0_rdy = 1'b1; disp_src1_rdy = 1'b1;
    disp_dst_tag = 6'd40; disp_seq = 5'd17; disp_valid = 1'b1;
    #1;
    check("R9", "iss_valid in flush", int'(iss_valid), 0);
    check("R9", "disp_ready in flush", int'(disp_ready), 0);
    tick();
    flush_valid = 1'b0; iss_ready = 1'b0; disp_valid = 1'b0;
    check("R8", "younger ready squashed", int'(iss_valid), 0);
    broadcast(30);
    pop_expect("R8", 30);
    pop_expect("R8", 31);
    broadcast(31);
    check("R8", "younger waiting squashed", int'(iss_valid), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_wakeup();
    t_capture();
    t_age();
    t_hold();
    t_full();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule